// File: doc/BRIEF.md
# Serial EEPROM Write-All Controller

This block is the slave side of a small serial EEPROM that sits on a three-wire bus: a chip select, a serial clock and a data input, plus one data output that has its own output-enable. All bus inputs are first brought into the system clock domain. The block then frames a command from a start bit, a 2-bit opcode and an 8-bit address. The array is a bank of 16-bit registers.

The main command replaces the contents of every word with one 16-bit value. It runs only after a write-enable command has been latched. It starts a self-timed cycle that lasts a fixed number of system clocks. During that cycle the whole array is first erased and then filled. The output pin can report whether this cycle is still running or has finished. Enable, disable and a single-word read command are included so that the effect of a write-all can be observed at the pins.

Top module: `mw_wral_ctrl`

## Requirements
- R1: On each rising serial clock edge with chip select high, the data input is sampled most significant bit first. A command is a start bit of 1, then 2 opcode bits, then 8 address bits. Zeros sampled before the start bit are skipped.
- R2: Opcode 00 with address bits [7:6] = 01, followed by 16 data bits, is a write-all. When its cycle ends, every array word reads back as the supplied data. The array is set to all ones when the cycle begins.
- R3: A write-all changes nothing and starts no cycle unless write-enable is set. Opcode 00 with address [7:6] = 11 sets write-enable, and opcode 00 with address [7:6] = 00 clears it.
- R4: With START_ON_CLK = 0, the cycle starts when chip select falls after the last data bit. With START_ON_CLK = 1, it starts on the serial clock edge that samples the last data bit.
- R5: The cycle lasts WRITE_CYCLES system clocks and finishes with the serial clock held idle.
- R6: Chip select may rise after staying low for at least CSL_MIN_CYCLES clocks, once a cycle has been started. In that case the output is enabled and shows 0 while the cycle runs and 1 after it ends. A shorter low time leaves the output disabled. The output is always disabled while chip select is low.
- R7: A start bit followed by chip select going low clears the ready/busy indication, unless that command itself started a cycle. The next chip select rise then leaves the output disabled.
- R8: Opcode 10 drives a 0 after the last address bit. Then, on each following serial clock rise, it drives the addressed word most significant bit first. The low address bits select the word.
- R9: Any command sent while a cycle is running is ignored.
- R10: If chip select falls before a command is complete, the command is dropped and the array is left unchanged.
- R11: After reset the array holds zeros, write-enable is clear and the output is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Bus chip select, active high |
| sclkIn | input | 1 | Bus serial clock |
| diIn | input | 1 | Bus serial data in |
| doOut | output | 1 | Serial data or ready/busy level |
| doOe | output | 1 | Output enable for doOut (0 means high impedance) |

## Verification
Two copies of the block, one per start variant, share the bus, so a single write-all held with chip select high separates the variants. One copy is still busy while the other is already ready. A controller that started its cycle on the wrong edge would show the same level in both. The bench also targets the short chip select low time, a start bit that clears the status, an attempt to overwrite during a cycle, a write-all while disabled or just after reset, and commands dropped partway through the address or data. A design that got these wrong would show status it should not, lose the status too early, or leave array contents that differ from the bench model.

// File: rtl/mw_wral_pkg.sv
package mw_wral_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_ARMED,
    ST_RDUMMY,
    ST_RDATA,
    ST_DONE
  } busState_t;

  typedef struct packed {
    logic shiftData;
    logic eraseAll;
    logic fillAll;
    logic loadRead;
    logic shiftRead;
  } dpStrobes_t;

  localparam logic [1:0] OPC_MISC = 2'b00;
  localparam logic [1:0] OPC_READ = 2'b10;
  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_WRAL = 2'b01;
  localparam logic [1:0] SUB_EN   = 2'b11;

endpackage

// File: rtl/mw_wral_array.sv
module mw_wral_array
  import mw_wral_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic             diSync,
  input  logic [IDX_W-1:0] readIdx,
  output logic             readBit
);

  logic [DATA_W-1:0] dataSr;
  logic [DATA_W-1:0] readSr;
  logic [DATA_W-1:0] memQ [DEPTH];

  // incoming word for write-all, filled one bit per strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataSr <= '0;
    end else if (strobes.shiftData) begin
      dataSr <= {dataSr[DATA_W-2:0], diSync};
    end
  end

  // every word has its own register; erase and fill reach all of them together
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        memQ[w] <= '0;
      end else if (strobes.eraseAll) begin
        memQ[w] <= '1;
      end else if (strobes.fillAll) begin
        memQ[w] <= dataSr;
      end
    end
  end

  // read path: parallel load, then shift left, one bit per serial clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readSr <= '0;
    end else if (strobes.loadRead) begin
      readSr <= memQ[readIdx];
    end else if (strobes.shiftRead) begin
      readSr <= {readSr[DATA_W-2:0], 1'b0};
    end
  end

  assign readBit = readSr[DATA_W-1];

  AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.eraseAll, strobes.fillAll, strobes.loadRead})); // R2
  AST_FILL_UNIFORM: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillAll |=> (memQ[0] == memQ[DEPTH-1])); // R2
  AST_ARRAY_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.eraseAll || strobes.fillAll) |=> $stable(memQ[0])); // R10

endmodule

// File: rtl/mw_wral_seq.sv
module mw_wral_seq
  import mw_wral_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int ADDR_W         = 8,
  parameter int DEPTH          = 16,
  parameter int WRITE_CYCLES   = 200,
  parameter int CSL_MIN_CYCLES = 13,
  parameter int SYNC_STAGES    = 2,
  parameter bit START_ON_CLK   = 1'b0,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int MAXLEN = (DATA_W > ADDR_W) ? DATA_W : ADDR_W,
  localparam int CNT_W  = $clog2(MAXLEN),
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1),
  localparam int CSL_W  = $clog2(CSL_MIN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIn,
  input  logic             sclkIn,
  input  logic             diIn,
  input  logic             readBit,
  output dpStrobes_t       strobes,
  output logic             diSync,
  output logic [IDX_W-1:0] readIdx,
  output logic             doOut,
  output logic             doOe
);

  localparam logic [CNT_W-1:0]  OPC_LAST  = CNT_W'(1);
  localparam logic [CNT_W-1:0]  ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(WRITE_CYCLES);
  localparam logic [CSL_W-1:0]  CSL_MIN   = CSL_W'(CSL_MIN_CYCLES);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, diPipe;
  logic csQ, sclkQ, diQ, csPrev, sclkPrev;
  logic sclkRise, csFall, csRise;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0] opcSr;
  logic [ADDR_W-1:0] addrSr, nextAddr;
  logic addrLast, dataLast, rdLast;
  logic wenQ;
  logic [BUSY_W-1:0] busyCnt;
  logic busy, cycleStart, startBit;
  logic [CSL_W-1:0] cslCnt;
  logic statusValid, statusOn, clrPend;
  logic readDrive;

  // bring the bus pins into the clk domain, equal depth keeps them aligned
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPipe   <= '0;
      sclkPipe <= '0;
      diPipe   <= '0;
      csPrev   <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], csIn};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      diPipe   <= {diPipe[SYNC_STAGES-2:0], diIn};
      csPrev   <= csQ;
      sclkPrev <= sclkQ;
    end
  end

  assign csQ      = csPipe[SYNC_STAGES-1];
  assign sclkQ    = sclkPipe[SYNC_STAGES-1];
  assign diQ      = diPipe[SYNC_STAGES-1];
  assign diSync   = diQ;
  assign sclkRise = sclkQ && !sclkPrev && csQ;
  assign csFall   = csPrev && !csQ;
  assign csRise   = csQ && !csPrev;

  assign nextAddr = {addrSr[ADDR_W-2:0], diQ};
  assign readIdx  = nextAddr[IDX_W-1:0];
  assign addrLast = (state == ST_ADDR) && (bitCnt == ADDR_LAST);
  assign dataLast = (state == ST_DATA) && (bitCnt == DATA_LAST);
  assign rdLast   = (state == ST_RDATA) && (bitCnt == DATA_LAST);
  assign busy     = (busyCnt != '0);
  assign startBit = sclkRise && (state == ST_IDLE) && diQ && !busy;

  // the variant parameter picks which event launches the timed cycle
  if (START_ON_CLK) begin : g_start_clk
    assign cycleStart = !busy && wenQ && sclkRise && dataLast;
  end else begin : g_start_cs
    assign cycleStart = !busy && wenQ && csFall && (state == ST_ARMED);
  end

  always_comb begin
    strobes           = '0;
    strobes.shiftData = sclkRise && (state == ST_DATA);
    strobes.eraseAll  = cycleStart;
    strobes.fillAll   = (busyCnt == BUSY_W'(1));
    strobes.loadRead  = sclkRise && addrLast && (opcSr == OPC_READ);
    strobes.shiftRead = sclkRise && (state == ST_RDATA) && !rdLast;
  end

  // command framing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      opcSr  <= '0;
      addrSr <= '0;
      wenQ   <= 1'b0;
    end else if (csFall) begin
      state <= ST_IDLE;
    end else if (sclkRise) begin
      unique case (state)
        ST_IDLE: begin
          if (diQ && !busy) begin
            state  <= ST_OPC;
            bitCnt <= '0;
          end
        end
        ST_OPC: begin
          opcSr <= {opcSr[0], diQ};
          if (bitCnt == OPC_LAST) begin
            state  <= ST_ADDR;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_ADDR: begin
          addrSr <= nextAddr;
          if (addrLast) begin
            bitCnt <= '0;
            if (opcSr == OPC_READ) begin
              state <= ST_RDUMMY;
            end else if (opcSr == OPC_MISC) begin
              unique case (nextAddr[ADDR_W-1 -: 2])
                SUB_WRAL: state <= ST_DATA;
                SUB_EN: begin
                  wenQ  <= 1'b1;
                  state <= ST_DONE;
                end
                SUB_DIS: begin
                  wenQ  <= 1'b0;
                  state <= ST_DONE;
                end
                default: state <= ST_DONE;
              endcase
            end else begin
              state <= ST_DONE;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (dataLast) begin
            state <= START_ON_CLK ? ST_DONE : ST_ARMED;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_RDUMMY: begin
          state  <= ST_RDATA;
          bitCnt <= '0;
        end
        ST_RDATA: begin
          if (rdLast) begin
            state <= ST_DONE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // self-timed cycle, runs on clk alone
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (cycleStart) begin
      busyCnt <= BUSY_LOAD;
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  // length of the current chip select low phase, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cslCnt <= '0;
    end else if (csQ) begin
      cslCnt <= '0;
    end else if (cslCnt != CSL_MIN) begin
      cslCnt <= cslCnt + 1'b1;
    end
  end

  // ready/busy indication: armed by a long enough low phase, cleared by a start bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusValid <= 1'b0;
      clrPend     <= 1'b0;
    end else if (cycleStart) begin
      statusValid <= 1'b1;
      clrPend     <= 1'b0;
    end else if (csFall) begin
      if (clrPend) statusValid <= 1'b0;
      clrPend <= 1'b0;
    end else if (startBit) begin
      clrPend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusOn <= 1'b0;
    end else if (csRise) begin
      statusOn <= statusValid && (cslCnt >= CSL_MIN);
    end else if (csFall && clrPend && !cycleStart) begin
      statusOn <= 1'b0;
    end
  end

  assign readDrive = (state == ST_RDUMMY) || (state == ST_RDATA);
  assign doOe      = csQ && (readDrive || statusOn);
  assign doOut     = readDrive ? ((state == ST_RDATA) && readBit) : !busy;

  AST_BUSY_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strobes.fillAll |=> busy); // R5
  AST_FILL_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillAll |=> !busy); // R5
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (state == ST_IDLE || state == ST_DONE)); // R9
  AST_STATUS_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    statusOn |-> statusValid); // R6
  AST_WEN_BY_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wenQ) |-> $past(state == ST_ADDR)); // R3
  AST_CYCLE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> wenQ); // R3

endmodule

// File: rtl/mw_wral_ctrl.sv
module mw_wral_ctrl
  import mw_wral_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int ADDR_W         = 8,
  parameter int DEPTH          = 16,
  parameter int WRITE_CYCLES   = 200,
  parameter int CSL_MIN_CYCLES = 13,
  parameter int SYNC_STAGES    = 2,
  parameter bit START_ON_CLK   = 1'b0,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);

  dpStrobes_t       strobes;
  logic             diSync;
  logic             readBit;
  logic [IDX_W-1:0] readIdx;

  mw_wral_seq #(
    .DATA_W         (DATA_W),
    .ADDR_W         (ADDR_W),
    .DEPTH          (DEPTH),
    .WRITE_CYCLES   (WRITE_CYCLES),
    .CSL_MIN_CYCLES (CSL_MIN_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES),
    .START_ON_CLK   (START_ON_CLK)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .csIn    (csIn),
    .sclkIn  (sclkIn),
    .diIn    (diIn),
    .readBit (readBit),
    .strobes (strobes),
    .diSync  (diSync),
    .readIdx (readIdx),
    .doOut   (doOut),
    .doOe    (doOe)
  );

  mw_wral_array #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_array (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .diSync  (diSync),
    .readIdx (readIdx),
    .readBit (readBit)
  );

endmodule

// File: tb/mw_wral_ctrl_bench.sv
module mw_wral_ctrl_bench;

  localparam int WC = 1500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0;
  logic sclkIn = 1'b0;
  logic diIn = 1'b0;
  logic doOut0, doOe0, doOut1, doOe1;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mw_wral_ctrl #(.WRITE_CYCLES(WC), .START_ON_CLK(1'b0)) u_mw_wral_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .diIn(diIn),
    .doOut(doOut0), .doOe(doOe0));

  mw_wral_ctrl #(.WRITE_CYCLES(WC), .START_ON_CLK(1'b1)) u_mw_wral_ctrl_clk (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .diIn(diIn),
    .doOut(doOut1), .doOe(doOe1));

  function automatic logic [15:0] expAfterWral(logic [15:0] prev, logic [15:0] data,
                                                bit en, bit complete);
    return (en && complete) ? data : prev;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    diIn = b;
    tick(6);
    sclkIn = 1'b1;
    tick(6);
    sclkIn = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic csHigh();
    csIn = 1'b1;
    tick(6);
  endtask

  task automatic csLow(input int n);
    csIn = 1'b0;
    diIn = 1'b0;
    sclkIn = 1'b0;
    tick(n);
  endtask

  task automatic statusBoth(input string req, input bit expOe, input bit expLvl);
    chk(doOe0 === expOe && (!expOe || doOut0 === expLvl), req,
        {doOe0, doOut0}, {expOe, expLvl});
    chk(doOe1 === expOe && (!expOe || doOut1 === expLvl), req,
        {doOe1, doOut1}, {expOe, expLvl});
  endtask

  // read one word from both copies; lead zeros are sent before the start bit
  task automatic readBoth(input logic [7:0] a, input int lead, input logic [15:0] exp,
                          input string req);
    logic [15:0] w0, w1;
    csHigh();
    if (lead > 0) sendBits(32'd0, lead);
    sendBits({21'd0, 3'b110, a}, 11);
    chk(doOe0 && !doOut0 && doOe1 && !doOut1, "R8 dummy bit",
        {doOe0, doOut0, doOe1, doOut1}, 4'b1010);
    for (int i = 15; i >= 0; i--) begin
      diIn = 1'b0;
      tick(6);
      sclkIn = 1'b1;
      tick(6);
      w0[i] = doOe0 ? doOut0 : 1'bx;
      w1[i] = doOe1 ? doOut1 : 1'bx;
      sclkIn = 1'b0;
    end
    csLow(20);
    chk(w0 === exp, req, w0, exp);
    chk(w1 === exp, req, w1, exp);
  endtask

  task automatic wralBits(input logic [15:0] d, input logic [5:0] low, input int nData);
    sendBits({21'd0, 3'b100, 2'b01, low}, 11);
    for (int i = 15; i > 15 - nData; i--) pulse(d[i]);
  endtask

  task automatic miscCmd(input logic [7:0] a);
    csHigh();
    sendBits({21'd0, 3'b100, a}, 11);
    csLow(20);
  endtask

  initial begin
    logic [15:0] model;
    bit wenModel;
    void'($urandom(32'h5EED));
    model = 16'h0000;
    wenModel = 1'b0;
    tick(5);
    rstN = 1'b1;
    tick(3);

    // R11: reset state
    statusBoth("R11 output off after reset", 1'b0, 1'b0);
    // R1: leading zeros before the start bit; R11: array zero
    readBoth(8'h3C, 3, 16'h0000, "R1 R11 read after reset");

    // R3: write-enable clear at reset, write-all must not act
    csHigh();
    wralBits(16'hBEEF, 6'h11, 16);
    csLow(20);
    tick(WC + 40);
    csHigh();
    statusBoth("R3 no cycle without enable", 1'b0, 1'b0);
    csLow(20);
    model = expAfterWral(model, 16'hBEEF, wenModel, 1'b1);
    readBoth(8'h07, 0, model, "R3 disabled write-all");

    // R2, R5, R6: enabled write-all with status
    miscCmd(8'hC5);
    wenModel = 1'b1;
    csHigh();
    wralBits(16'hA5C3, 6'h0F, 16);
    csLow(20);
    csHigh();
    statusBoth("R6 busy after long low", 1'b1, 1'b0);
    tick(WC + 40);
    statusBoth("R5 ready with clock idle", 1'b1, 1'b1);
    csLow(20);
    statusBoth("R6 off while cs low", 1'b0, 1'b0);
    model = expAfterWral(model, 16'hA5C3, wenModel, 1'b1);
    readBoth(8'h00, 0, model, "R2 first word");
    // R7: the read's start bit and cs low cleared the indication
    csHigh();
    statusBoth("R7 status cleared", 1'b0, 1'b0);
    csLow(20);
    readBoth(8'hFF, 0, model, "R2 last word");

    // R6 short low, R9 overwrite attempt during cycle
    csHigh();
    wralBits(16'h1234, 6'h2A, 16);
    csLow(3);
    csHigh();
    statusBoth("R6 short low keeps output off", 1'b0, 1'b0);
    csLow(20);
    csHigh();
    statusBoth("R6 busy after second long low", 1'b1, 1'b0);
    wralBits(16'hFFFF, 6'h00, 16);
    csLow(20);
    tick(WC + 40);
    model = expAfterWral(model, 16'h1234, wenModel, 1'b1);
    readBoth(8'h05, 0, model, "R9 command while busy ignored");

    // R3: disable then write-all
    miscCmd(8'h2A);
    wenModel = 1'b0;
    csHigh();
    wralBits(16'h0F0F, 6'h33, 16);
    csLow(20);
    tick(WC + 40);
    model = expAfterWral(model, 16'h0F0F, wenModel, 1'b1);
    readBoth(8'h0A, 0, model, "R3 write-all after disable");

    // R10: aborts in the data and in the address
    miscCmd(8'hFF);
    wenModel = 1'b1;
    csHigh();
    wralBits(16'hC0DE, 6'h01, 10);
    csLow(20);
    tick(WC + 40);
    csHigh();
    sendBits({25'd0, 3'b100, 4'b0100}, 7);
    csLow(20);
    tick(WC + 40);
    model = expAfterWral(model, 16'hC0DE, wenModel, 1'b0);
    readBoth(8'h0C, 0, model, "R10 aborted commands");

    // R4: cycle start point differs by variant
    csHigh();
    wralBits(16'h5A5A, 6'h3F, 16);
    tick(WC + 40);
    csLow(20);
    csHigh();
    chk(doOe0 && !doOut0, "R4 cs-edge variant still busy", {doOe0, doOut0}, 2'b10);
    chk(doOe1 && doOut1, "R4 clock-edge variant ready", {doOe1, doOut1}, 2'b11);
    csLow(20);
    tick(WC + 40);
    model = expAfterWral(model, 16'h5A5A, wenModel, 1'b1);
    readBoth(8'h09, 0, model, "R2 R4 both variants written");

    // R2: random data and random read addresses
    for (int k = 0; k < 4; k++) begin
      logic [15:0] d;
      logic [7:0] a;
      d = 16'($urandom);
      a = 8'($urandom);
      csHigh();
      wralBits(d, 6'($urandom), 16);
      csLow(20);
      tick(WC + 40);
      model = expAfterWral(model, d, wenModel, 1'b1);
      readBoth(a, k % 3, model, "R2 random write-all");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule